// File: doc/BRIEF.md
# Priority Thread Scheduler

This block picks, on every clock cycle, which hardware thread of a multithreaded processor pipeline supplies the next instruction fetch. It tracks a fixed set of N threads. Each holds a ready or blocked state and one of four priority levels. The last thread, number N-1, is a permanent idle thread. Block and wake request vectors move threads between the blocked (wait) set and the ready (run) set. Priorities are written through a small configuration port before scheduling starts. After that they are frozen.

In the default priority mode, the most urgent ready level always wins, so a newly woken urgent thread takes over the pipeline. Threads that share a level take turns. A separate round-robin mode ignores priorities and steps through the ready threads in circular ID order, one per cycle.

The selection output is a plain registered thread ID with a valid flag. The fetch stage takes it every cycle and cannot apply back-pressure, so the output carries no ready signal. Once reset is released the flag stays high.

Top module: `thread_sched`

## Requirements
- R1: Levels use a 2-bit code, with 0 the most urgent and 3 the idle level. Thread N-1 is fixed at level 3, and configuration writes addressed to it are ignored. A write of level 3 to any other thread is stored as level 2.
- R2: In priority mode (rr_mode=0) the selected thread belongs to the most urgent level that holds a ready thread. A thread of a less urgent level is never selected while a more urgent thread is ready.
- R3: In priority mode, when several ready threads share the winning level, the pick is the first ready thread of that level in circular ID order after the last thread picked at that level. The threads therefore rotate one per cycle.
- R4: A set bit in block_req removes that thread from the ready set, and a set bit in wake_req puts it back. If both bits are set for the same thread in one cycle, the wake wins.
- R5: The idle thread is always ready and a block request for it has no effect. It is selected whenever no other thread is ready.
- R6: Configuration writes (cfg_we with cfg_tid and cfg_lvl) take effect only until the first cycle in which any wake_req bit is set. From the cycle after that, writes are ignored until reset.
- R7: In round-robin mode (rr_mode=1) priorities are ignored. The pick is the first ready thread in circular ID order after the currently output sel_tid.
- R8: A block or wake request sampled at clock edge k changes the ready set at edge k. The selection registered at edge k+1 reflects it, which is a two-edge latency.
- R9: Synchronous active-high reset blocks every thread except the idle thread. It sets all application levels to 2, clears the per-level rotation pointers and sel_tid to 0, and drives sel_valid low. From the first edge after reset is released, sel_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Priority configuration write strobe |
| cfg_tid | input | $clog2(N) | Thread addressed by a configuration write |
| cfg_lvl | input | 2 | Priority level to write (0 most urgent) |
| rr_mode | input | 1 | 1 selects plain round-robin, 0 selects priority mode |
| block_req | input | N | One bit per thread: move the thread to the wait set |
| wake_req | input | N | One bit per thread: move the thread to the run set |
| sel_tid | output | $clog2(N) | Thread selected for the next fetch |
| sel_valid | output | 1 | sel_tid is meaningful |

## Verification
A table walks the threads through wake and block steps with exactly one thread at each top level. This separates correct level ordering and preemption from a scheduler that favours the lowest ID or the most recent request, and it includes a same-cycle block and wake of one thread. Three threads at a single level are then run for consecutive cycles to show rotation rather than a fixed pick. The same ready set is then run in round-robin mode, where the idle thread must appear in turn, which a priority-only scheduler would never allow. Directed steps cover configuration after the lock, clamping of level 3, writes to the idle thread, block requests for the idle thread, the one-edge gap before a new thread shows, and the reset values.

// File: rtl/tsched_pkg.sv
package tsched_pkg;
  localparam int LVLS = 4;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_TOP      = 2'd0;
  localparam lvl_t LVL_APP_LOW  = 2'd2;
  localparam lvl_t LVL_IDLE     = 2'd3;
endpackage

// File: rtl/ts_state.sv
module ts_state
  import tsched_pkg::*;
#(
  parameter int N  = 8,
  parameter int TW = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [TW-1:0]         cfg_tid,
  input  lvl_t                  cfg_lvl,
  input  logic [N-1:0]          block_req,
  input  logic [N-1:0]          wake_req,
  output logic [N-1:0]          ready_q,
  output logic [N-1:0][1:0]     lvl_q,
  output logic                  locked
);
  localparam logic [N-1:0] IDLE_BIT = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] APP_MASK = ~IDLE_BIT;

  logic cfg_hit;
  lvl_t cfg_val;

  assign cfg_hit = cfg_we && !locked && (int'(cfg_tid) < N - 1);
  assign cfg_val = (cfg_lvl == LVL_IDLE) ? LVL_APP_LOW : cfg_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= IDLE_BIT;
      locked  <= 1'b0;
      for (int t = 0; t < N; t++) begin
        lvl_q[t] <= (t == N - 1) ? LVL_IDLE : LVL_APP_LOW;
      end
    end else begin
      ready_q <= (ready_q & ~(block_req & APP_MASK)) | wake_req | IDLE_BIT;
      if (|wake_req) locked <= 1'b1;
      if (cfg_hit) lvl_q[cfg_tid] <= cfg_val;
    end
  end
endmodule

// File: rtl/ts_circ_pick.sv
module ts_circ_pick #(
  parameter int N  = 8,
  parameter int TW = 3
) (
  input  logic [N-1:0]  req,
  input  logic [TW-1:0] after,
  output logic          any,
  output logic [TW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = 1; k <= N; k++) begin
      int c;
      c = (int'(after) + k) % N;
      if (!any && req[c]) begin
        any = 1'b1;
        idx = TW'(c);
      end
    end
  end
endmodule

// File: rtl/ts_arbiter.sv
module ts_arbiter
  import tsched_pkg::*;
#(
  parameter int N  = 8,
  parameter int TW = 3
) (
  input  logic [N-1:0]           ready,
  input  logic [N-1:0][1:0]      lvl,
  input  logic                   rr_mode,
  input  logic [TW-1:0]          last_sel,
  input  logic [LVLS-1:0][TW-1:0] lvl_ptr,
  output logic                   pick_any,
  output logic [TW-1:0]          pick_idx,
  output lvl_t                   pick_lvl
);
  logic [LVLS-1:0][N-1:0]  lvl_mask;
  logic [LVLS-1:0]         lvl_any;
  logic [LVLS-1:0][TW-1:0] lvl_idx;
  logic                    rr_any;
  logic [TW-1:0]           rr_idx;

  for (genvar g = 0; g < LVLS; g++) begin : g_lvl
    for (genvar t = 0; t < N; t++) begin : g_bit
      assign lvl_mask[g][t] = ready[t] && (lvl[t] == lvl_t'(g));
    end
    ts_circ_pick #(.N(N), .TW(TW)) u_pick (
      .req  (lvl_mask[g]),
      .after(lvl_ptr[g]),
      .any  (lvl_any[g]),
      .idx  (lvl_idx[g])
    );
  end

  ts_circ_pick #(.N(N), .TW(TW)) u_rr (
    .req  (ready),
    .after(last_sel),
    .any  (rr_any),
    .idx  (rr_idx)
  );

  always_comb begin
    pick_any = 1'b0;
    pick_idx = '0;
    pick_lvl = LVL_IDLE;
    if (rr_mode) begin
      pick_any = rr_any;
      pick_idx = rr_idx;
    end else begin
      for (int g = LVLS - 1; g >= 0; g--) begin
        if (lvl_any[g]) begin
          pick_any = 1'b1;
          pick_idx = lvl_idx[g];
          pick_lvl = lvl_t'(g);
        end
      end
    end
  end
endmodule

// File: rtl/thread_sched.sv
module thread_sched
  import tsched_pkg::*;
#(
  parameter  int N  = 8,
  localparam int TW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [TW-1:0] cfg_tid,
  input  logic [1:0]    cfg_lvl,
  input  logic          rr_mode,
  input  logic [N-1:0]  block_req,
  input  logic [N-1:0]  wake_req,
  output logic [TW-1:0] sel_tid,
  output logic          sel_valid
);
  logic [N-1:0]            ready_q;
  logic [N-1:0][1:0]       lvl_q;
  logic                    locked;
  logic [LVLS-1:0][TW-1:0] lvl_ptr;
  logic                    pick_any;
  logic [TW-1:0]           pick_idx;
  lvl_t                    pick_lvl;

  ts_state #(.N(N), .TW(TW)) u_state (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_tid  (cfg_tid),
    .cfg_lvl  (cfg_lvl),
    .block_req(block_req),
    .wake_req (wake_req),
    .ready_q  (ready_q),
    .lvl_q    (lvl_q),
    .locked   (locked)
  );

  ts_arbiter #(.N(N), .TW(TW)) u_arb (
    .ready   (ready_q),
    .lvl     (lvl_q),
    .rr_mode (rr_mode),
    .last_sel(sel_tid),
    .lvl_ptr (lvl_ptr),
    .pick_any(pick_any),
    .pick_idx(pick_idx),
    .pick_lvl(pick_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_tid   <= '0;
      sel_valid <= 1'b0;
      lvl_ptr   <= '0;
    end else begin
      sel_valid <= pick_any;
      if (pick_any) begin
        sel_tid <= pick_idx;
        if (!rr_mode) lvl_ptr[pick_lvl] <= pick_idx;
      end
    end
  end
endmodule

// File: rtl/thread_sched_chk.sv
module thread_sched_chk #(
  parameter int N  = 8,
  parameter int TW = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [N-1:0]      ready,
  input logic [N-1:0][1:0] lvl,
  input logic              locked,
  input logic              rr_mode,
  input logic [N-1:0]      block_req,
  input logic [N-1:0]      wake_req,
  input logic [TW-1:0]     sel_tid,
  input logic              sel_valid
);
  localparam logic [N-1:0] APP_MASK = {1'b0, {(N-1){1'b1}}};

  logic              prev_ok;
  logic [N-1:0]      prev_ready;
  logic [N-1:0][1:0] prev_lvl;
  logic              prev_rr;
  logic [TW-1:0]     prev_sel;
  logic              higher_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_ok    <= 1'b0;
      prev_ready <= '0;
      prev_lvl   <= '0;
      prev_rr    <= 1'b0;
      prev_sel   <= '0;
    end else begin
      prev_ok    <= 1'b1;
      prev_ready <= ready;
      prev_lvl   <= lvl;
      prev_rr    <= rr_mode;
      prev_sel   <= sel_tid;
    end
  end

  always_comb begin
    higher_ready = 1'b0;
    for (int t = 0; t < N; t++) begin
      if (prev_ready[t] && (prev_lvl[t] < prev_lvl[sel_tid])) higher_ready = 1'b1;
    end
  end

  AST_VALID_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    !rst |=> sel_valid); // R9
  AST_PICK_IS_READY: assert property (@(posedge clk) disable iff (rst)
    (prev_ok && sel_valid) |-> prev_ready[sel_tid]); // R8
  AST_NO_URGENT_SKIPPED: assert property (@(posedge clk) disable iff (rst)
    (prev_ok && sel_valid && !prev_rr) |-> !higher_ready); // R2
  AST_IDLE_ALWAYS_READY: assert property (@(posedge clk) disable iff (rst)
    !rst |-> ready[N-1]); // R5
  AST_WAKE_WINS: assert property (@(posedge clk) disable iff (rst)
    (|wake_req) |=> ((ready & $past(wake_req)) == $past(wake_req))); // R4
  AST_BLOCK_TAKES: assert property (@(posedge clk) disable iff (rst)
    (|(block_req & ~wake_req & APP_MASK)) |=>
      ((ready & $past(block_req & ~wake_req & APP_MASK)) == '0)); // R4
  AST_LEVELS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(lvl)); // R6
  AST_RR_MOVES_ON: assert property (@(posedge clk) disable iff (rst)
    (prev_ok && prev_rr && ($countones(prev_ready) > 1)) |-> (sel_tid != prev_sel)); // R7
endmodule

bind thread_sched thread_sched_chk #(.N(N), .TW(TW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ready    (ready_q),
  .lvl      (lvl_q),
  .locked   (locked),
  .rr_mode  (rr_mode),
  .block_req(block_req),
  .wake_req (wake_req),
  .sel_tid  (sel_tid),
  .sel_valid(sel_valid)
);

// File: tb/sim_thread_sched.sv
module sim_thread_sched;
  localparam int CLK_P = 10;
  localparam int N     = 8;
  localparam int TW    = 3;
  localparam int NV    = 8;

  localparam logic [N-1:0] V_BLK [NV] = '{
    8'h00, 8'h00, 8'h00, 8'h01, 8'h02, 8'h08, 8'h08, 8'h80 };
  localparam logic [N-1:0] V_WK  [NV] = '{
    8'h08, 8'h02, 8'h01, 8'h00, 8'h00, 8'h08, 8'h00, 8'h00 };
  localparam logic [TW-1:0] V_EXP [NV] = '{
    3'd3, 3'd1, 3'd0, 3'd1, 3'd3, 3'd3, 3'd7, 3'd7 };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [TW-1:0] cfg_tid = '0;
  logic [1:0]    cfg_lvl = '0;
  logic          rr_mode = 1'b0;
  logic [N-1:0]  block_req = '0;
  logic [N-1:0]  wake_req = '0;
  logic [TW-1:0] sel_tid;
  logic          sel_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  thread_sched #(.N(N)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_tid(cfg_tid), .cfg_lvl(cfg_lvl),
    .rr_mode(rr_mode), .block_req(block_req), .wake_req(wake_req),
    .sel_tid(sel_tid), .sel_valid(sel_valid)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [N-1:0] blk, input logic [N-1:0] wk);
    block_req = blk;
    wake_req  = wk;
    tick();
    block_req = '0;
    wake_req  = '0;
    tick();
  endtask

  task automatic cfg(input int tid, input int lv);
    cfg_we  = 1'b1;
    cfg_tid = TW'(tid);
    cfg_lvl = 2'(lv);
    tick();
    cfg_we  = 1'b0;
  endtask

  function automatic logic [TW-1:0] next_in(input logic [N-1:0] set, input logic [TW-1:0] cur);
    logic [TW-1:0] r;
    bit hit;
    r = cur;
    hit = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int c;
      c = (int'(cur) + k) % N;
      if (!hit && set[c]) begin
        hit = 1'b1;
        r = TW'(c);
      end
    end
    return r;
  endfunction

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [TW-1:0] s;
    tick();
    tick();
    check("R9 reset sel_valid", 32'(sel_valid), 0);
    check("R9 reset sel_tid", 32'(sel_tid), 0);
    rst = 1'b0;
    tick();
    check("R9 valid after reset", 32'(sel_valid), 1);
    check("R5 idle when nothing ready", 32'(sel_tid), 7);

    // priorities: t0=0 t1=1 t2=1 t3=3->2 (R1 clamp) t4=2 t5=0 t6=1, idle write ignored (R1)
    cfg(0, 0); cfg(1, 1); cfg(2, 1); cfg(3, 3);
    cfg(4, 2); cfg(5, 0); cfg(6, 1); cfg(7, 0);

    for (int i = 0; i < NV; i++) begin
      pulse(V_BLK[i], V_WK[i]);
      check($sformatf("R2/R4/R5 table step %0d", i), 32'(sel_tid), 32'(V_EXP[i]));
      if (i == 0) begin
        tick();
        check("R1 level-3 write stored as 2, no tie with idle", 32'(sel_tid), 3);
      end
    end

    // R6: write after lock ignored (t5 stays level 0); R8: one-edge gap
    cfg(5, 2);
    block_req = '0;
    wake_req  = 8'h28;
    tick();
    wake_req  = '0;
    check("R8 not yet visible after first edge", 32'(sel_tid), 7);
    tick();
    check("R6 locked level kept, t5 preempts t3", 32'(sel_tid), 5);
    tick();
    check("R2 urgent thread held", 32'(sel_tid), 5);
    pulse(8'h28, 8'h00);
    check("R4 both blocked, idle back", 32'(sel_tid), 7);

    // R3: same-level rotation among t1, t2, t6
    pulse(8'h00, 8'h46);
    s = sel_tid;
    check("R2 pick inside level-1 set", 32'((s == 1) || (s == 2) || (s == 6)), 1);
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R3 rotation at shared level", 32'(sel_tid), 32'(next_in(8'h46, s)));
      s = sel_tid;
    end

    // R7: round-robin ignores levels, idle takes its turn
    rr_mode = 1'b1;
    for (int k = 0; k < 5; k++) begin
      s = sel_tid;
      tick();
      check("R7 circular pick over ready set", 32'(sel_tid), 32'(next_in(8'hC6, s)));
    end
    rr_mode = 1'b0;

    // R9: reset mid-run blocks application threads again
    rst = 1'b1;
    tick();
    check("R9 reset drops valid", 32'(sel_valid), 0);
    rst = 1'b0;
    tick();
    check("R9 only idle ready after reset", 32'(sel_tid), 7);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule